// File: doc/BRIEF.md
# Dual 8-bit cascadable compare timer

Two independent 8-bit up-counters share one byte/halfword register port. Each counter is clocked from a shared free-running prescaler through its own divisor select, compares its count against two match registers, can restart from zero on either match, and raises single-cycle interrupt pulses on match A, match B and overflow. Six pulse outputs result, three per channel.

Channel 0 can be switched into a chained mode in which the two counters behave as one 16-bit counter, with channel 0 supplying the high byte of the count and of both match values. In that mode the channel-0 control bits govern clearing and interrupts, the chained count is clocked from channel 1's divisor, and channel 1 raises no interrupts. Separately, channel 1 can be set to advance once per channel-0 match-A event instead of from the prescaler.

Fields for external clocking, pin actions and converter triggers are stored and read back but have no effect.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, reads return: control 0x00 on both channels, status 0x00 on channel 0 and 0x10 on channel 1, match A and match B 0xFF, counters 0x00, clock control 0x00, and all six interrupt outputs are low.
- R2: Register offsets (address bits 3:1) are control 0, status 1, match A 2, match B 3, counter 4, clock control 5; address bit 0 picks channel 1. Byte reads return the value in bits 7:0 with bits 15:8 zero. Control keeps bits 7:3 (others read 0), status keeps bits 5:0, clock control keeps bits 7 and 4:0.
- R3: Channel-1 status bits 5:4 always read as 01, whatever was written.
- R4: A halfword access at an even address of match A, match B, counter or clock control carries channel 0 in bits 15:8 and channel 1 in bits 7:0, for both reads and writes.
- R5: A halfword access at an odd address, or to control or status, is illegal: a write changes nothing and a read returns 0xFFFF. Byte reads of offsets 6 and 7 also return 0xFFFF.
- R6: Clock control bits 2:0 select a divisor of stopped, 1, 2, 8, 32, 64, 1024, 8192 (codes 0..7); with source bits 4:3 = 1 the counter advances by one every divisor clock cycles. Code 0, or source 0 or 2, freezes the counter.
- R7: On a count tick where the count equals match A, a match-A event occurs; if control bits 4:3 = 1 the next value is zero (period = match A + 1 ticks), and if control bit 6 is set the match-A output pulses high for exactly the cycle after that tick.
- R8: Match B behaves the same way, with control bits 4:3 = 2 selecting the clear and control bit 7 the pulse.
- R9: A tick at count 0xFF that does not clear wraps to 0x00 and, if control bit 5 is set, pulses the overflow output; a clear at 0xFF gives no overflow.
- R10: With channel-0 source = 3 the pair counts as one 16-bit value (channel 0 high byte) clocked by channel 1's divisor when channel 1's source is 1; 16-bit match and clear use channel-0 control, overflow is at 0xFFFF to 0x0000, and channel-1 outputs stay low.
- R11: With channel-1 source = 3 and channel 0 not chained, channel 1 advances once on every channel-0 match-A event.
- R12: A register write in the same cycle as a count update takes precedence for the register written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_half | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 4 | Byte address within the block |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 16 | Combinational read data for bus_addr/bus_half |
| irq_cmpa | output | 2 | Match-A pulse per channel |
| irq_cmpb | output | 2 | Match-B pulse per channel |
| irq_ovf | output | 2 | Overflow pulse per channel |

## Verification
The hardest state to reach is a chained 16-bit overflow, which would need 65536 ticks from reset; the bench instead preloads the counter pair through one halfword write to 0xFFF0 with the clock stopped and only then starts channel 1's divisor, so the wrap comes after 16 cycles. The chained match is driven the same way with a 16-bit match value whose low and high bytes differ, so any byte-order slip shows up as a wrong period. Slow divisors are measured over windows that are whole multiples of the divisor, making the tick count independent of the prescaler phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH    = 2;
    localparam int BW     = 8;
    localparam int DW     = 2 * BW;
    localparam int ADDR_W = 4;
    localparam int PSC_W  = 13;

    // register offsets, address bits 3:1
    localparam logic [2:0] OFS_CTRL = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd1;
    localparam logic [2:0] OFS_CMPA = 3'd2;
    localparam logic [2:0] OFS_CMPB = 3'd3;
    localparam logic [2:0] OFS_CNT  = 3'd4;
    localparam logic [2:0] OFS_CKC  = 3'd5;

    localparam logic [BW-1:0] CTRL_MASK = 8'hF8;
    localparam logic [BW-1:0] STAT_MASK = 8'h3F;
    localparam logic [BW-1:0] CKC_MASK  = 8'h9F;

    localparam int IE_OVF = 5;
    localparam int IE_A   = 6;
    localparam int IE_B   = 7;

    localparam logic [1:0] CLR_ON_A  = 2'd1;
    localparam logic [1:0] CLR_ON_B  = 2'd2;
    localparam logic [1:0] SRC_INT   = 2'd1;
    localparam logic [1:0] SRC_CHAIN = 2'd3;

    typedef struct packed {
        logic [BW-1:0] ctrl;
        logic [BW-1:0] stat;
        logic [BW-1:0] cmpa;
        logic [BW-1:0] cmpb;
        logic [BW-1:0] cnt;
        logic [BW-1:0] ckc;
    } chan_t;

    typedef struct packed {
        chan_t [NCH-1:0]  ch;
        logic  [NCH-1:0]  irq_a;
        logic  [NCH-1:0]  irq_b;
        logic  [NCH-1:0]  irq_o;
    } state_t;

    function automatic chan_t chan_reset(input logic is_ch1);
        chan_t r;
        r.ctrl = '0;
        r.stat = is_ch1 ? 8'h10 : 8'h00;
        r.cmpa = '1;
        r.cmpb = '1;
        r.cnt  = '0;
        r.ckc  = '0;
        return r;
    endfunction

    // low bits that must be all ones for a prescaler tick
    function automatic logic [PSC_W-1:0] div_mask(input logic [2:0] sel);
        logic [PSC_W-1:0] m;
        case (sel)
            3'd2:    m = PSC_W'(1);
            3'd3:    m = PSC_W'(7);
            3'd4:    m = PSC_W'(31);
            3'd5:    m = PSC_W'(63);
            3'd6:    m = PSC_W'(1023);
            3'd7:    m = PSC_W'(8191);
            default: m = '0;
        endcase
        return m;
    endfunction

    function automatic logic access_bad(input logic [ADDR_W-1:0] a, input logic half);
        logic [2:0] ofs;
        ofs = a[3:1];
        return (ofs > OFS_CKC) ||
               (half && (a[0] || ofs == OFS_CTRL || ofs == OFS_STAT));
    endfunction

    function automatic chan_t put_reg(input chan_t r, input logic [2:0] ofs,
                                      input logic [BW-1:0] v);
        chan_t o;
        o = r;
        case (ofs)
            OFS_CTRL: o.ctrl = v & CTRL_MASK;
            OFS_STAT: o.stat = v & STAT_MASK;
            OFS_CMPA: o.cmpa = v;
            OFS_CMPB: o.cmpb = v;
            OFS_CNT:  o.cnt  = v;
            OFS_CKC:  o.ckc  = v & CKC_MASK;
            default:  o      = r;
        endcase
        return o;
    endfunction

    function automatic logic [BW-1:0] get_reg(input chan_t r, input logic [2:0] ofs,
                                              input logic is_ch1);
        logic [BW-1:0] v;
        case (ofs)
            OFS_CTRL: v = r.ctrl;
            OFS_STAT: v = is_ch1 ? {r.stat[7:6], 2'b01, r.stat[3:0]} : r.stat;
            OFS_CMPA: v = r.cmpa;
            OFS_CMPB: v = r.cmpb;
            OFS_CNT:  v = r.cnt;
            OFS_CKC:  v = r.ckc;
            default:  v = '1;
        endcase
        return v;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0][2:0] sel,
    output logic [N-1:0]     tick
);
    logic [PSC_W-1:0] free_q;
    logic [PSC_W-1:0] free_d;

    always_comb begin
        free_d = free_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_q <= '0;
        else        free_q <= free_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_tick
        logic [PSC_W-1:0] mask;
        always_comb begin
            mask    = div_mask(sel[g]);
            tick[g] = (sel[g] != 3'd0) && ((free_q & mask) == mask);
        end
    end
endmodule

// File: rtl/tmr_step.sv
module tmr_step #(
    parameter int W = 8
) (
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmpa,
    input  logic [W-1:0] cmpb,
    input  logic [1:0]   clr_sel,
    output logic [W-1:0] cnt_nxt,
    output logic         hit_a,
    output logic         hit_b,
    output logic         wrap
);
    logic clear;

    always_comb begin
        hit_a   = tick && (cnt == cmpa);
        hit_b   = tick && (cnt == cmpb);
        clear   = (hit_a && clr_sel == 2'd1) || (hit_b && clr_sel == 2'd2);
        wrap    = tick && !clear && (&cnt);
        cnt_nxt = !tick ? cnt : (clear ? '0 : cnt + 1'b1);
    end
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
    import tmr_pkg::*;
(
    input  chan_t [NCH-1:0]    regs,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               half,
    output logic [DW-1:0]      rdata
);
    logic [2:0] ofs;

    always_comb begin
        ofs = addr[3:1];
        if (access_bad(addr, half))
            rdata = '1;
        else if (half)
            rdata = {get_reg(regs[0], ofs, 1'b0), get_reg(regs[1], ofs, 1'b1)};
        else
            rdata = {{BW{1'b0}}, get_reg(regs[addr[0]], ofs, addr[0])};
    end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_half,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NCH-1:0]    irq_cmpa,
    output logic [NCH-1:0]    irq_cmpb,
    output logic [NCH-1:0]    irq_ovf
);
    state_t st_q;
    state_t st_d;

    logic [NCH-1:0]      psc_tick;
    logic [NCH-1:0][2:0] psc_sel;
    logic                chain;
    logic                tick_c0, tick_c1, tick_w;
    logic [BW-1:0]       nxt_c0, nxt_c1;
    logic [DW-1:0]       nxt_w;
    logic                ha_c0, hb_c0, wr_c0;
    logic                ha_c1, hb_c1, wr_c1;
    logic                ha_w, hb_w, wr_w;

    // observation taps for the bound checker
    logic [NCH-1:0][BW-1:0] mon_cnt, mon_ctrl, mon_ckc, mon_cmpa;

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            psc_sel[c]  = st_q.ch[c].ckc[2:0];
            mon_cnt[c]  = st_q.ch[c].cnt;
            mon_ctrl[c] = st_q.ch[c].ctrl;
            mon_ckc[c]  = st_q.ch[c].ckc;
            mon_cmpa[c] = st_q.ch[c].cmpa;
        end
    end

    tmr_prescaler #(.N(NCH)) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (psc_sel),
        .tick  (psc_tick)
    );

    always_comb begin
        chain   = st_q.ch[0].ckc[4:3] == SRC_CHAIN;
        tick_c0 = !chain && st_q.ch[0].ckc[4:3] == SRC_INT && psc_tick[0];
        tick_w  = chain && st_q.ch[1].ckc[4:3] == SRC_INT && psc_tick[1];
    end

    always_comb begin
        case (st_q.ch[1].ckc[4:3])
            SRC_INT:   tick_c1 = !chain && psc_tick[1];
            SRC_CHAIN: tick_c1 = !chain && ha_c0;
            default:   tick_c1 = 1'b0;
        endcase
    end

    tmr_step #(.W(BW)) u_step0 (
        .tick(tick_c0), .cnt(st_q.ch[0].cnt), .cmpa(st_q.ch[0].cmpa),
        .cmpb(st_q.ch[0].cmpb), .clr_sel(st_q.ch[0].ctrl[4:3]),
        .cnt_nxt(nxt_c0), .hit_a(ha_c0), .hit_b(hb_c0), .wrap(wr_c0)
    );

    tmr_step #(.W(BW)) u_step1 (
        .tick(tick_c1), .cnt(st_q.ch[1].cnt), .cmpa(st_q.ch[1].cmpa),
        .cmpb(st_q.ch[1].cmpb), .clr_sel(st_q.ch[1].ctrl[4:3]),
        .cnt_nxt(nxt_c1), .hit_a(ha_c1), .hit_b(hb_c1), .wrap(wr_c1)
    );

    tmr_step #(.W(DW)) u_step_wide (
        .tick(tick_w),
        .cnt({st_q.ch[0].cnt, st_q.ch[1].cnt}),
        .cmpa({st_q.ch[0].cmpa, st_q.ch[1].cmpa}),
        .cmpb({st_q.ch[0].cmpb, st_q.ch[1].cmpb}),
        .clr_sel(st_q.ch[0].ctrl[4:3]),
        .cnt_nxt(nxt_w), .hit_a(ha_w), .hit_b(hb_w), .wrap(wr_w)
    );

    tmr_rdmux u_rd (
        .regs  (st_q.ch),
        .addr  (bus_addr),
        .half  (bus_half),
        .rdata (bus_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.irq_a = '0;
        st_d.irq_b = '0;
        st_d.irq_o = '0;

        if (chain) begin
            {st_d.ch[0].cnt, st_d.ch[1].cnt} = nxt_w;
            st_d.irq_a[0] = ha_w && st_q.ch[0].ctrl[IE_A];
            st_d.irq_b[0] = hb_w && st_q.ch[0].ctrl[IE_B];
            st_d.irq_o[0] = wr_w && st_q.ch[0].ctrl[IE_OVF];
        end else begin
            st_d.ch[0].cnt = nxt_c0;
            st_d.ch[1].cnt = nxt_c1;
            st_d.irq_a     = {ha_c1 && st_q.ch[1].ctrl[IE_A],   ha_c0 && st_q.ch[0].ctrl[IE_A]};
            st_d.irq_b     = {hb_c1 && st_q.ch[1].ctrl[IE_B],   hb_c0 && st_q.ch[0].ctrl[IE_B]};
            st_d.irq_o     = {wr_c1 && st_q.ch[1].ctrl[IE_OVF], wr_c0 && st_q.ch[0].ctrl[IE_OVF]};
        end

        // bus write overrides the count update of the register it hits
        if (bus_wr && !access_bad(bus_addr, bus_half)) begin
            if (bus_half) begin
                st_d.ch[0] = put_reg(st_d.ch[0], bus_addr[3:1], bus_wdata[DW-1:BW]);
                st_d.ch[1] = put_reg(st_d.ch[1], bus_addr[3:1], bus_wdata[BW-1:0]);
            end else begin
                st_d.ch[bus_addr[0]] = put_reg(st_d.ch[bus_addr[0]], bus_addr[3:1],
                                               bus_wdata[BW-1:0]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ch[0] <= chan_reset(1'b0);
            st_q.ch[1] <= chan_reset(1'b1);
            st_q.irq_a <= '0;
            st_q.irq_b <= '0;
            st_q.irq_o <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_cmpa = st_q.irq_a;
    assign irq_cmpb = st_q.irq_b;
    assign irq_ovf  = st_q.irq_o;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic                   bus_half,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [DW-1:0]          bus_rdata,
    input logic [NCH-1:0]         irq_cmpa,
    input logic [NCH-1:0]         irq_cmpb,
    input logic [NCH-1:0]         irq_ovf,
    input logic [NCH-1:0][BW-1:0] mon_cnt,
    input logic [NCH-1:0][BW-1:0] mon_ctrl,
    input logic [NCH-1:0][BW-1:0] mon_ckc,
    input logic [NCH-1:0][BW-1:0] mon_cmpa
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        a_r7_cmpa_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            irq_cmpa[c] |-> $past(mon_ctrl[c][IE_A]));
        a_r8_cmpb_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            irq_cmpb[c] |-> $past(mon_ctrl[c][IE_B]));
        a_r9_ovf_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
            irq_ovf[c] |-> $past(mon_ctrl[c][IE_OVF]));
    end

    a_r6_ch0_external_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_ckc[0][4:3] == 2'd0 && !bus_wr) |=> $stable(mon_cnt[0]));

    a_r6_ch1_stopped_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_ckc[1][4:3] == SRC_INT && mon_ckc[1][2:0] == 3'd0 &&
         mon_ckc[0][4:3] != SRC_CHAIN && !bus_wr) |=> $stable(mon_cnt[1]));

    a_r7_clear_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_ckc[0] == 8'h09 && mon_ctrl[0][4:3] == CLR_ON_A &&
         mon_cnt[0] == mon_cmpa[0] && !bus_wr) |=> (mon_cnt[0] == '0));

    a_r10_chain_ch1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_ckc[0][4:3] == SRC_CHAIN) |=> (irq_cmpa[1] == 1'b0 && irq_cmpb[1] == 1'b0 &&
                                            irq_ovf[1] == 1'b0));

    a_r5_bad_half_read: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_half && (bus_addr[0] || bus_addr[3:1] <= OFS_STAT)) |-> (bus_rdata == '1));

    a_r3_ch1_stat_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_half && bus_addr == 4'h3) |-> (bus_rdata[5:4] == 2'b01));
endmodule

bind dual_cmp_timer tmr_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_half  (bus_half),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_cmpa  (irq_cmpa),
    .irq_cmpb  (irq_cmpb),
    .irq_ovf   (irq_ovf),
    .mon_cnt   (mon_cnt),
    .mon_ctrl  (mon_ctrl),
    .mon_ckc   (mon_ckc),
    .mon_cmpa  (mon_cmpa)
);

// File: tb/dual_cmp_timer_tb_top.sv
module dual_cmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_half = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  irq_cmpa, irq_cmpb, irq_ovf;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_cmp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_half(bus_half),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic h, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_half = h; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, input logic h, output logic [15:0] d);
        bus_addr = a; bus_half = h;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic h,
                          input logic [15:0] exp);
        logic [15:0] d;
        peek(a, h, d);
        chk(tag, d, exp);
    endtask

    // periodic clear sweep: R7 (match A) or R8 (match B)
    task automatic sweep(input logic ch, input logic use_b, input int v);
        logic [15:0] d;
        int lim;
        wr(4'hA, 1'b1, 16'h0000);
        wr(4'h8, 1'b1, 16'h0000);
        if (use_b) begin
            wr({3'd3, ch}, 1'b0, 16'(v));
            wr({3'd0, ch}, 1'b0, 16'h0090);
        end else begin
            wr({3'd2, ch}, 1'b0, 16'(v));
            wr({3'd0, ch}, 1'b0, 16'h0048);
        end
        wr({3'd5, ch}, 1'b0, 16'h0009);
        lim = 3 * (v + 1) + 2;
        for (int n = 0; n <= lim; n++) begin
            peek({3'd4, ch}, 1'b0, d);
            chk(use_b ? "R8 count" : "R7 count", d, 16'(n % (v + 1)));
            chk(use_b ? "R8 pulse" : "R7 pulse",
                {15'b0, use_b ? irq_cmpb[ch] : irq_cmpa[ch]},
                {15'b0, (n > 0 && n % (v + 1) == 0)});
            @(negedge clk);
        end
    endtask

    task automatic rate(input logic [7:0] ckc, input int win, input int exp_adv);
        logic [15:0] c0, c1;
        wr(4'hA, 1'b0, {8'h00, ckc});
        peek(4'h8, 1'b0, c0);
        repeat (win) @(negedge clk);
        peek(4'h8, 1'b0, c1);
        chk("R6 advance", (c1 - c0) & 16'h00FF, 16'(exp_adv));
    endtask

    initial begin : watchdog
        repeat (195000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd_chk("R1 ctrl0", 4'h0, 1'b0, 16'h0000);
        rd_chk("R1 ctrl1", 4'h1, 1'b0, 16'h0000);
        rd_chk("R1 stat0", 4'h2, 1'b0, 16'h0000);
        rd_chk("R1 stat1", 4'h3, 1'b0, 16'h0010);
        rd_chk("R1 cmpa",  4'h4, 1'b1, 16'hFFFF);
        rd_chk("R1 cmpb",  4'h6, 1'b1, 16'hFFFF);
        rd_chk("R1 cnt",   4'h8, 1'b1, 16'h0000);
        rd_chk("R1 ckc",   4'hA, 1'b1, 16'h0000);
        chk("R1 irqs", {10'b0, irq_cmpa, irq_cmpb, irq_ovf}, 16'h0000);

        // R2 masks, R3 status bits
        wr(4'h0, 1'b0, 16'h00FF); rd_chk("R2 ctrl mask", 4'h0, 1'b0, 16'h00F8);
        wr(4'h2, 1'b0, 16'h00FF); rd_chk("R2 stat mask", 4'h2, 1'b0, 16'h003F);
        wr(4'hB, 1'b0, 16'h00FF); rd_chk("R2 ckc mask",  4'hB, 1'b0, 16'h009F);
        wr(4'h3, 1'b0, 16'h00FF); rd_chk("R3 stat1 ff",  4'h3, 1'b0, 16'h001F);
        wr(4'h3, 1'b0, 16'h0000); rd_chk("R3 stat1 00",  4'h3, 1'b0, 16'h0010);
        wr(4'h0, 1'b0, 16'h0000);
        wr(4'hA, 1'b1, 16'h0000);

        // R4 halfword pairing
        wr(4'h4, 1'b1, 16'hA55A);
        rd_chk("R4 byte ch0", 4'h4, 1'b0, 16'h00A5);
        rd_chk("R4 byte ch1", 4'h5, 1'b0, 16'h005A);
        rd_chk("R4 half",     4'h4, 1'b1, 16'hA55A);

        // R5 illegal accesses
        wr(4'h5, 1'b1, 16'h1234);
        rd_chk("R5 odd write dropped", 4'h4, 1'b1, 16'hA55A);
        wr(4'h0, 1'b1, 16'hFFFF);
        rd_chk("R5 ctrl half write dropped", 4'h0, 1'b0, 16'h0000);
        rd_chk("R5 ctrl1 unchanged", 4'h1, 1'b0, 16'h0000);
        rd_chk("R5 stat half read", 4'h2, 1'b1, 16'hFFFF);
        rd_chk("R5 odd half read",  4'h9, 1'b1, 16'hFFFF);
        rd_chk("R5 unmapped byte",  4'hC, 1'b0, 16'hFFFF);

        // R7 and R8 sweeps
        for (int i = 0; i < 6; i++) begin
            int vals[6] = '{0, 1, 2, 7, 100, 255};
            sweep(1'b0, 1'b0, vals[i]);
        end
        for (int i = 0; i < 3; i++) begin
            int vals[3] = '{0, 3, 200};
            sweep(1'b1, 1'b1, vals[i]);
        end

        // R9 overflow, and no overflow on a clear at 0xFF
        wr(4'hA, 1'b1, 16'h0000);
        wr(4'h0, 1'b0, 16'h0020);
        wr(4'h4, 1'b0, 16'h0010);
        wr(4'h6, 1'b0, 16'h0010);
        wr(4'h8, 1'b0, 16'h00F8);
        wr(4'hA, 1'b0, 16'h0009);
        for (int n = 0; n <= 20; n++) begin
            peek(4'h8, 1'b0, d);
            chk("R9 count", d, 16'((8'hF8 + n) & 8'hFF));
            chk("R9 overflow pulse", {15'b0, irq_ovf[0]}, {15'b0, n == 8});
            @(negedge clk);
        end
        wr(4'hA, 1'b1, 16'h0000);
        wr(4'h0, 1'b0, 16'h0028);
        wr(4'h4, 1'b0, 16'h00FF);
        wr(4'h8, 1'b0, 16'h00F8);
        wr(4'hA, 1'b0, 16'h0009);
        for (int n = 0; n <= 20; n++) begin
            peek(4'h8, 1'b0, d);
            chk("R9 clear count", d, 16'((8'hF8 + n) & 8'hFF));
            chk("R9 no ovf on clear", {15'b0, irq_ovf[0]}, 16'h0000);
            chk("R7 disabled no pulse", {15'b0, irq_cmpa[0]}, 16'h0000);
            @(negedge clk);
        end

        // R6 prescaler rates
        wr(4'hA, 1'b1, 16'h0000);
        wr(4'h0, 1'b0, 16'h0000);
        rate(8'h0B, 64, 8);
        rate(8'h0A, 16, 8);
        rate(8'h0C, 64, 2);
        rate(8'h0D, 128, 2);
        rate(8'h0E, 2048, 2);
        rate(8'h0F, 16384, 2);
        rate(8'h09, 10, 10);
        rate(8'h08, 100, 0);
        rate(8'h01, 100, 0);
        rate(8'h11, 100, 0);

        // R11 channel 1 counts channel-0 match-A events
        wr(4'hA, 1'b1, 16'h0000);
        wr(4'h0, 1'b0, 16'h0008);
        wr(4'h1, 1'b0, 16'h0000);
        wr(4'h4, 1'b0, 16'h0003);
        wr(4'h8, 1'b1, 16'h0000);
        wr(4'hB, 1'b0, 16'h0018);
        wr(4'hA, 1'b0, 16'h0009);
        for (int n = 0; n <= 40; n++) begin
            peek(4'h8, 1'b1, d);
            chk("R11 event count", d, {8'(n % 4), 8'(n / 4)});
            @(negedge clk);
        end

        // R10 chained 16-bit compare with clear
        wr(4'hA, 1'b1, 16'h0000);
        wr(4'h0, 1'b0, 16'h0048);
        wr(4'h1, 1'b0, 16'h00E0);
        wr(4'h4, 1'b1, 16'h0123);
        wr(4'h6, 1'b1, 16'hFFFF);
        wr(4'h8, 1'b1, 16'h0000);
        wr(4'hA, 1'b0, 16'h0018);
        wr(4'hB, 1'b0, 16'h0009);
        for (int n = 0; n <= 3 * 16'h124 + 2; n++) begin
            peek(4'h8, 1'b1, d);
            chk("R10 chained count", d, 16'(n % 16'h124));
            chk("R10 chained pulse", {15'b0, irq_cmpa[0]}, {15'b0, (n > 0 && n % 16'h124 == 0)});
            chk("R10 ch1 quiet", {13'b0, irq_cmpa[1], irq_cmpb[1], irq_ovf[1]}, 16'h0000);
            @(negedge clk);
        end

        // R10 chained overflow at 0xFFFF
        wr(4'hA, 1'b1, 16'h0000);
        wr(4'h0, 1'b0, 16'h0020);
        wr(4'h4, 1'b1, 16'hFFFF);
        wr(4'h8, 1'b1, 16'hFFF0);
        wr(4'hA, 1'b0, 16'h0018);
        wr(4'hB, 1'b0, 16'h0009);
        for (int n = 0; n <= 30; n++) begin
            peek(4'h8, 1'b1, d);
            chk("R10 wrap count", d, 16'(16'hFFF0 + n));
            chk("R10 wrap pulse", {15'b0, irq_ovf[0]}, {15'b0, n == 16});
            chk("R10 ch1 ovf quiet", {15'b0, irq_ovf[1]}, 16'h0000);
            @(negedge clk);
        end

        // R12 write wins over a count update
        wr(4'hA, 1'b1, 16'h0000);
        wr(4'h0, 1'b0, 16'h0000);
        wr(4'h4, 1'b0, 16'h00FF);
        wr(4'h8, 1'b0, 16'h0000);
        wr(4'hA, 1'b0, 16'h0009);
        repeat (5) @(negedge clk);
        wr(4'h8, 1'b0, 16'h0040);
        rd_chk("R12 written value", 4'h8, 1'b0, 16'h0040);
        @(negedge clk);
        rd_chk("R12 next tick", 4'h8, 1'b0, 16'h0041);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule